// File: doc/BRIEF.md
# Time-Sliced Display/Processor/DMA Memory Arbiter

This block shares a single memory port among three masters: a display fetch engine, the processor bus and a DMA engine. A free-running slot phase alternates every memory cycle. Even slots always belong to the display engine, whether or not it is asking for memory. Odd slots go to the processor. While the DMA engine holds its active flag, the odd slots go to DMA and the processor is stalled.

Each memory cycle lasts one clock period of the arbiter clock, nominally an 8 MHz clock matched to a memory with a 120 ns access time. The block reports which master owns the current slot through a two-bit address-path select. It also raises a wait output for any master whose request is not served in that cycle. Grants and waits are combinational from the registered slot phase and the current requests, so a requester sees its grant or wait in the same cycle as its request.

Top module: `vidmem_slot_arbiter`

## Requirements
- R1: During reset `slot_phase` is 0 (display slot). After reset is released, it inverts at every clock edge, so the first cycle after release is a processor/DMA slot.
- R2: In a display slot (`slot_phase`=0), `addr_sel` is 2'b01 (display) and `disp_gnt` equals `disp_req`.
- R3: In a display slot, `cpu_gnt` and `dma_gnt` are 0 for every combination of the other inputs.
- R4: In an odd slot with `dma_active`=0 and `cpu_req`=1, `cpu_gnt` is 1 and `addr_sel` is 2'b10 (processor).
- R5: `cpu_wait` is 1 exactly in cycles where `cpu_req`=1 and `cpu_gnt`=0. A request raised in a display slot therefore waits one cycle and is granted in the next slot.
- R6: In an odd slot with `dma_active`=1, `cpu_gnt` is 0. If `dma_req`=1 as well, `dma_gnt` is 1 and `addr_sel` is 2'b11 (DMA).
- R7: While `dma_active`=0, `dma_gnt` is never 1. `dma_wait` is 1 exactly when `dma_req`=1 and `dma_gnt`=0.
- R8: An odd slot with no processor or DMA grant drives `addr_sel` to 2'b00 (idle), and `disp_gnt` stays 0 even if `disp_req`=1.
- R9: At most one of `disp_gnt`, `cpu_gnt` and `dma_gnt` is 1 in any cycle.
- R10: `disp_wait` is 1 exactly when `disp_req`=1 in an odd slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_req | input | 1 | Display fetch engine wants memory |
| cpu_req | input | 1 | Processor bus cycle pending |
| dma_req | input | 1 | DMA engine wants memory |
| dma_active | input | 1 | DMA owns the non-display slots |
| disp_gnt | output | 1 | Display served this cycle |
| cpu_gnt | output | 1 | Processor served this cycle |
| dma_gnt | output | 1 | DMA served this cycle |
| disp_wait | output | 1 | Display request not served |
| cpu_wait | output | 1 | Processor stalled |
| dma_wait | output | 1 | DMA request not served |
| addr_sel | output | 2 | Address path owner: 00 idle, 01 display, 10 processor, 11 DMA |
| slot_phase | output | 1 | 0 = display slot, 1 = processor/DMA slot |

## Verification
The hardest case to reach is a processor request that is already pending when `dma_active` falls. The stall must end in the very next odd slot and must not be granted in the display slot between them. The stimulus holds `cpu_req` high through a DMA burst and drops `dma_active` on each slot phase in turn. A second sequence raises `cpu_req` in a display slot to exercise the one-cycle wait of R5.

// File: rtl/vidarb_pkg.sv
// Package: shared encodings for the slot arbiter.
// Assumes: two-slot time division, slot 0 reserved for display.
package vidarb_pkg;
    localparam int PHASE_W    = 1;
    localparam int SEL_W      = 2;
    localparam int N_MASTERS  = 3;
    localparam logic [PHASE_W-1:0] DISP_PHASE = '0;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDLE = 2'b00,
        SEL_DISP = 2'b01,
        SEL_CPU  = 2'b10,
        SEL_DMA  = 2'b11
    } mem_sel_e;

    // Index of each master in the grant/request vectors
    localparam int IDX_DISP = 0;
    localparam int IDX_CPU  = 1;
    localparam int IDX_DMA  = 2;
endpackage

// File: rtl/vidarb_phase_gen.sv
// Slot phase counter: free-running, reset to the display phase.
// Assumes one memory cycle per clock.
module vidarb_phase_gen
    import vidarb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase,
    output logic               disp_slot
);
    logic [PHASE_W-1:0] phase_q;

    // Advance the slot phase every memory cycle
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= DISP_PHASE;
        else        phase_q <= phase_q + 1'b1;
    end

    // Decode the display-owned slot
    always_comb begin
        phase     = phase_q;
        disp_slot = (phase_q == DISP_PHASE);
    end
endmodule

// File: rtl/vidarb_owner_dec.sv
// Slot owner decode: picks who drives the address path this cycle.
// Display owns its slot unconditionally; DMA displaces the processor
// in the other slot while active; an unused slot stays idle.
module vidarb_owner_dec
    import vidarb_pkg::*;
(
    input  logic     disp_slot,
    input  logic     cpu_req,
    input  logic     dma_req,
    input  logic     dma_active,
    output mem_sel_e owner
);
    // Choose the slot owner
    always_comb begin
        if (disp_slot)                  owner = SEL_DISP;
        else if (dma_active && dma_req) owner = SEL_DMA;
        else if (!dma_active && cpu_req) owner = SEL_CPU;
        else                            owner = SEL_IDLE;
    end
endmodule

// File: rtl/vidarb_grant_out.sv
// Grant and wait generation from the slot owner and the requests.
// Assumes owner only names a master whose slot it is.
module vidarb_grant_out
    import vidarb_pkg::*;
(
    input  mem_sel_e               owner,
    input  logic [N_MASTERS-1:0]   req,
    output logic [N_MASTERS-1:0]   gnt,
    output logic [N_MASTERS-1:0]   wait_o
);
    localparam mem_sel_e OWN_CODE [N_MASTERS] = '{SEL_DISP, SEL_CPU, SEL_DMA};

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_master
        // Grant a master when it owns the slot and is asking
        always_comb begin
            gnt[g]    = req[g] && (owner == OWN_CODE[g]);
            wait_o[g] = req[g] && !gnt[g];
        end
    end
endmodule

// File: rtl/vidmem_slot_arbiter.sv
// Top: time-sliced memory arbiter for display, processor and DMA.
// Assumes one memory cycle per clock and requests stable per cycle.
module vidmem_slot_arbiter
    import vidarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             cpu_req,
    input  logic             dma_req,
    input  logic             dma_active,
    output logic             disp_gnt,
    output logic             cpu_gnt,
    output logic             dma_gnt,
    output logic             disp_wait,
    output logic             cpu_wait,
    output logic             dma_wait,
    output logic [SEL_W-1:0] addr_sel,
    output logic             slot_phase
);
    logic [PHASE_W-1:0]   phase;
    logic                 disp_slot;
    mem_sel_e             owner;
    logic [N_MASTERS-1:0] req_v;
    logic [N_MASTERS-1:0] gnt_v;
    logic [N_MASTERS-1:0] wait_v;

    vidarb_phase_gen i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .disp_slot (disp_slot)
    );

    vidarb_owner_dec i_owner (
        .disp_slot  (disp_slot),
        .cpu_req    (cpu_req),
        .dma_req    (dma_req),
        .dma_active (dma_active),
        .owner      (owner)
    );

    // Pack requests into the master-indexed vector
    always_comb begin
        req_v           = '0;
        req_v[IDX_DISP] = disp_req;
        req_v[IDX_CPU]  = cpu_req;
        req_v[IDX_DMA]  = dma_req;
    end

    vidarb_grant_out i_gnt (
        .owner  (owner),
        .req    (req_v),
        .gnt    (gnt_v),
        .wait_o (wait_v)
    );

    // Unpack grants, waits and the path select onto the ports
    always_comb begin
        disp_gnt   = gnt_v[IDX_DISP];
        cpu_gnt    = gnt_v[IDX_CPU];
        dma_gnt    = gnt_v[IDX_DMA];
        disp_wait  = wait_v[IDX_DISP];
        cpu_wait   = wait_v[IDX_CPU];
        dma_wait   = wait_v[IDX_DMA];
        addr_sel   = (owner == SEL_DISP || gnt_v != '0) ? owner : SEL_IDLE;
        slot_phase = phase[0];
    end
endmodule

// File: rtl/vidarb_checker.sv
// Checker: temporal properties of the slot arbiter, bound to the top.
module vidarb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       disp_req,
    input logic       cpu_req,
    input logic       dma_req,
    input logic       dma_active,
    input logic       disp_gnt,
    input logic       cpu_gnt,
    input logic       dma_gnt,
    input logic       disp_wait,
    input logic       cpu_wait,
    input logic       dma_wait,
    input logic [1:0] addr_sel,
    input logic       slot_phase
);
    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_phase != $past(slot_phase)); // R1
    AST_DISP_SLOT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_phase |-> addr_sel == 2'b01); // R2
    AST_DISP_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_phase |-> !cpu_gnt && !dma_gnt); // R3
    AST_CPU_SERVED_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && !slot_phase && !dma_active) ##1 (cpu_req && !dma_active) |-> cpu_gnt); // R5
    AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_phase && dma_active && dma_req) |-> dma_gnt && !cpu_gnt && cpu_wait == cpu_req); // R6
    AST_DMA_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_active |-> !dma_gnt); // R7
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_gnt, cpu_gnt, dma_gnt})); // R9
    AST_DISP_WAIT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_wait |-> slot_phase && !disp_gnt); // R10
endmodule

bind vidmem_slot_arbiter vidarb_checker i_vidarb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_req   (disp_req),
    .cpu_req    (cpu_req),
    .dma_req    (dma_req),
    .dma_active (dma_active),
    .disp_gnt   (disp_gnt),
    .cpu_gnt    (cpu_gnt),
    .dma_gnt    (dma_gnt),
    .disp_wait  (disp_wait),
    .cpu_wait   (cpu_wait),
    .dma_wait   (dma_wait),
    .addr_sel   (addr_sel),
    .slot_phase (slot_phase)
);

// File: tb/test_vidmem_slot_arbiter.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module test_vidmem_slot_arbiter;
    localparam int CLK_P = 125;

    typedef struct packed {
        logic [1:0] sel;
        logic       phase;
        logic       dg, cg, mg, dw, cw, mw;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_req = 1'b0, cpu_req = 1'b0, dma_req = 1'b0, dma_active = 1'b0;
    logic disp_gnt, cpu_gnt, dma_gnt, disp_wait, cpu_wait, dma_wait;
    logic [1:0] addr_sel;
    logic slot_phase;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    vidmem_slot_arbiter i_vidmem_slot_arbiter (
        .clk(clk), .rst_n(rst_n),
        .disp_req(disp_req), .cpu_req(cpu_req), .dma_req(dma_req), .dma_active(dma_active),
        .disp_gnt(disp_gnt), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
        .disp_wait(disp_wait), .cpu_wait(cpu_wait), .dma_wait(dma_wait),
        .addr_sel(addr_sel), .slot_phase(slot_phase)
    );

    // Expected outputs from the requirements
    function automatic exp_t predict(input logic ph, input logic d, input logic c,
                                     input logic m, input logic act);
        exp_t e;
        e = '0;
        e.phase = ph;                               // R1
        if (!ph) begin
            e.sel = 2'b01; e.dg = d;                // R2, R3
        end else if (act) begin
            e.mg = m;                               // R6
            e.sel = m ? 2'b11 : 2'b00;
        end else begin
            e.cg = c;                               // R4, R7
            e.sel = c ? 2'b10 : 2'b00;              // R8
        end
        e.dw = d && !e.dg;                          // R10
        e.cw = c && !e.cg;                          // R5
        e.mw = m && !e.mg;                          // R7
        return e;
    endfunction

    task automatic check1(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expectation
    task automatic drive(input logic d, input logic c, input logic m, input logic act);
        @(negedge clk);
        if (rst_n) cyc++;
        disp_req = d; cpu_req = c; dma_req = m; dma_active = act;
        sb_q.push_back(predict(rst_n ? cyc[0] : 1'b0, d, c, m, act));
    endtask

    // Monitor: compare a quarter period after each drive
    always @(negedge clk) begin
        #(CLK_P/4);
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check1("R1 slot_phase", {1'b0, slot_phase}, {1'b0, e.phase});
            check1("R2/R4/R6/R8 addr_sel", addr_sel, e.sel);
            check1("R2 disp_gnt", {1'b0, disp_gnt}, {1'b0, e.dg});
            check1("R3/R4 cpu_gnt", {1'b0, cpu_gnt}, {1'b0, e.cg});
            check1("R6/R7 dma_gnt", {1'b0, dma_gnt}, {1'b0, e.mg});
            check1("R5 cpu_wait", {1'b0, cpu_wait}, {1'b0, e.cw});
            check1("R7 dma_wait", {1'b0, dma_wait}, {1'b0, e.mw});
            check1("R10 disp_wait", {1'b0, disp_wait}, {1'b0, e.dw});
            check1("R9 onehot", {1'b0, ($countones({disp_gnt, cpu_gnt, dma_gnt}) > 1)}, 2'b00);
        end
    end

    initial begin
        logic [7:0] lfsr;
        // R1 reset state
        drive(0, 0, 0, 0);
        drive(1, 1, 1, 1);
        @(negedge clk);
        rst_n = 1'b1; cyc = 0;
        // R4/R5: steady processor requests
        for (int i = 0; i < 6; i++) drive(0, 1, 0, 0);
        // R2/R8/R10: display requests in both phases
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 0);
        // R9: all three requesting, no DMA active
        for (int i = 0; i < 4; i++) drive(1, 1, 1, 0);
        // R6: DMA burst stalling a held processor request, then release on each phase
        for (int i = 0; i < 5; i++) drive(1, 1, 1, 1);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);
        for (int i = 0; i < 4; i++) drive(0, 1, 1, 1);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);
        // R6: active but DMA idle, processor still stalled
        for (int i = 0; i < 4; i++) drive(0, 1, 0, 1);
        // R7: DMA asking without the active flag
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 0);
        // R5: processor raises request in a display slot
        drive(0, 0, 0, 0);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        // Pseudo-random mix of all inputs
        lfsr = 8'hA5;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[0], lfsr[1], lfsr[2], lfsr[3] & lfsr[5]);
        end
        drive(0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule